// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-Up Sequencer

This block is a controller-side state machine that powers up the endpoint side of a root-port link and trains it. On a start request it steps through a fixed, timed sequence. The endpoint supply is cycled off and then on. The reference clock is enabled and the core soft reset is released, with a settling wait before the PHY reset is cleared. The endpoint fundamental reset is held and then released with a recovery wait. The maximum link speed field is then forced to generation 1 and LTSSM training is enabled.

While training, the block polls the link status at a fixed interval. The link counts as up only when the link-up flag is set and the in-training flag is clear. A stalled speed change is detected when the receiver-valid flag is low and the LTSSM state code is 0x0D. In that case the block applies a timed pulse on both receiver overrides and then resumes polling. The outcome is reported as a done level with an error flag. All delays come from a single down-counter loaded with cycles-per-microsecond times the delay in microseconds, so a bench can shorten them.

Top module: `pcie_link_bringup`

## Requirements
- R1: After reset the block is idle: endpoint power off, reference clock off, core soft reset asserted, PHY reset asserted, fundamental reset asserted (perst_n_o low), LTSSM disabled, overrides off, max_speed_o equal to DEF_SPEED, busy_o, done_o and err_o low.
- R2: Counting the edge that samples start as edge 0, endpoint power stays low until edge CYC_PER_US*PWR_US and rises there. It then stays high for another CYC_PER_US*PWR_US cycles before the next step.
- R3: After the second power wait, refclk_en_o rises and core_rst_o falls. Exactly CYC_PER_US*SETTLE_US cycles later, phy_rst_o falls.
- R4: perst_n_o stays low for CYC_PER_US*PERST_US cycles after the PHY reset clears, then rises. Training waits a further CYC_PER_US*PERST_US cycles.
- R5: max_speed_o changes from DEF_SPEED to 1 exactly one cycle before ltssm_en_o rises. It stays 1 while training is enabled.
- R6: A poll succeeds only when link_up_i is 1 and in_train_i is 0. Success raises done_o with err_o low at that poll.
- R7: Polls happen every CYC_PER_US*POLL_US cycles of polling time; the first poll is that many cycles after ltssm_en_o rises. After MAX_POLLS polls without success, done_o rises with err_o high. A success on the last poll is reported as success.
- R8: When a poll fails, is not the last poll, and sees rx_valid_i at 0 with ltssm_i equal to 6'h0D, both rx_data_ovr_o and rx_pll_ovr_o go high together for CYC_PER_US*OVR_US cycles. They then clear, and polling resumes with a fresh interval.
- R9: The overrides are never raised when rx_valid_i is 1 or when ltssm_i differs from 6'h0D.
- R10: A start while busy_o is high has no effect on the sequence timing. A start while idle or finished restarts the sequence from the powered-off state.
- R11: done_o and err_o hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the bring-up sequence |
| link_up_i | input | 1 | Link-up flag from the link core |
| in_train_i | input | 1 | Link-in-training flag |
| ltssm_i | input | 6 | LTSSM state code |
| rx_valid_i | input | 1 | PHY receiver-valid flag |
| ep_pwr_o | output | 1 | Endpoint power enable |
| refclk_en_o | output | 1 | Reference clock enable |
| core_rst_o | output | 1 | Core soft reset, active high |
| phy_rst_o | output | 1 | PHY reset and power-down, active high |
| perst_n_o | output | 1 | Endpoint fundamental reset, active low |
| ltssm_en_o | output | 1 | LTSSM training enable |
| max_speed_o | output | 4 | Maximum link speed field |
| rx_data_ovr_o | output | 1 | Receiver data-enable override |
| rx_pll_ovr_o | output | 1 | Receiver PLL-enable override |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| err_o | output | 1 | Bring-up timed out |

## Verification
The sequence runs under a shortened timing configuration. Every output edge is compared with its position computed arithmetically from the delay parameters. Link status patterns cover the following cases:
- a link that is up from the start;
- a link that is up but stays in training;
- a link that stays stuck in the receiver-lock state with no valid receiver;
- two near-miss states, either a wrong state code or a valid receiver;
- a link that comes up at each poll index from the first to the last.

The near-miss states show whether the stuck test needs both conditions. The poll sweep separates an off-by-one poll count from the rule that success wins on the last poll. Extra start pulses during and after a run show that a start while busy is ignored and that a start when finished is honoured.

// File: rtl/pcie_link_bringup.sv
module pcie_link_bringup #(
  parameter int CYC_PER_US = 100,
  parameter int PWR_US     = 20000,
  parameter int SETTLE_US  = 50000,
  parameter int PERST_US   = 20000,
  parameter int POLL_US    = 10,
  parameter int OVR_US     = 3000,
  parameter int MAX_POLLS  = 4000,
  parameter logic [3:0] DEF_SPEED = 4'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       link_up_i,
  input  logic       in_train_i,
  input  logic [5:0] ltssm_i,
  input  logic       rx_valid_i,
  output logic       ep_pwr_o,
  output logic       refclk_en_o,
  output logic       core_rst_o,
  output logic       phy_rst_o,
  output logic       perst_n_o,
  output logic       ltssm_en_o,
  output logic [3:0] max_speed_o,
  output logic       rx_data_ovr_o,
  output logic       rx_pll_ovr_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  function automatic int max_us();
    int m;
    m = PWR_US;
    if (SETTLE_US > m) m = SETTLE_US;
    if (PERST_US > m) m = PERST_US;
    if (POLL_US > m) m = POLL_US;
    if (OVR_US > m) m = OVR_US;
    return m;
  endfunction

  localparam int CW  = $clog2(CYC_PER_US * max_us() + 1);
  localparam int PCW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] L_PWR    = CW'(CYC_PER_US * PWR_US - 1);
  localparam logic [CW-1:0] L_SETTLE = CW'(CYC_PER_US * SETTLE_US - 1);
  localparam logic [CW-1:0] L_PERST  = CW'(CYC_PER_US * PERST_US - 1);
  localparam logic [CW-1:0] L_POLL   = CW'(CYC_PER_US * POLL_US - 1);
  localparam logic [CW-1:0] L_OVR    = CW'(CYC_PER_US * OVR_US - 1);
  localparam logic [PCW-1:0] LAST_POLL = PCW'(MAX_POLLS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PWR_LO, S_PWR_HI, S_SETTLE, S_PERST_LO, S_PERST_HI,
    S_ENA, S_POLL, S_OVR, S_UP, S_FAIL
  } state_t;

  state_t         state;
  logic [CW-1:0]  cnt;
  logic [PCW-1:0] polls;

  wire expired = (cnt == '0);
  wire link_ok = link_up_i && !in_train_i;
  wire stuck   = !rx_valid_i && (ltssm_i == 6'h0D);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      polls <= '0;
    end else begin
      case (state)
        S_IDLE, S_UP, S_FAIL:
          if (start) begin
            state <= S_PWR_LO;
            cnt   <= L_PWR;
            polls <= '0;
          end
        S_PWR_LO:
          if (expired) begin state <= S_PWR_HI; cnt <= L_PWR; end
          else cnt <= cnt - 1'b1;
        S_PWR_HI:
          if (expired) begin state <= S_SETTLE; cnt <= L_SETTLE; end
          else cnt <= cnt - 1'b1;
        S_SETTLE:
          if (expired) begin state <= S_PERST_LO; cnt <= L_PERST; end
          else cnt <= cnt - 1'b1;
        S_PERST_LO:
          if (expired) begin state <= S_PERST_HI; cnt <= L_PERST; end
          else cnt <= cnt - 1'b1;
        S_PERST_HI:
          if (expired) state <= S_ENA;
          else cnt <= cnt - 1'b1;
        S_ENA: begin
          state <= S_POLL;
          cnt   <= L_POLL;
        end
        S_POLL:
          if (!expired) cnt <= cnt - 1'b1;
          else begin
            polls <= polls + 1'b1;
            if (link_ok) state <= S_UP;
            else if (polls == LAST_POLL) state <= S_FAIL;
            else if (stuck) begin state <= S_OVR; cnt <= L_OVR; end
            else cnt <= L_POLL;
          end
        S_OVR:
          if (expired) begin state <= S_POLL; cnt <= L_POLL; end
          else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ep_pwr_o      = (state >= S_PWR_HI);
  assign refclk_en_o   = (state >= S_SETTLE);
  assign core_rst_o    = (state <  S_SETTLE);
  assign phy_rst_o     = (state <  S_PERST_LO);
  assign perst_n_o     = (state >= S_PERST_HI);
  assign ltssm_en_o    = (state >= S_POLL);
  assign max_speed_o   = (state >= S_ENA) ? 4'd1 : DEF_SPEED;
  assign rx_data_ovr_o = (state == S_OVR);
  assign rx_pll_ovr_o  = (state == S_OVR);
  assign busy_o        = (state != S_IDLE) && (state != S_UP) && (state != S_FAIL);
  assign done_o        = (state == S_UP) || (state == S_FAIL);
  assign err_o         = (state == S_FAIL);

  AST_PERST_AFTER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_n_o) |-> ep_pwr_o && refclk_en_o && !phy_rst_o && !core_rst_o); // R4
  AST_GEN1_BEFORE_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltssm_en_o) |-> $past(max_speed_o) == 4'd1); // R5
  AST_UP_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) && !err_o |-> $past(link_up_i && !in_train_i)); // R6
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    polls <= PCW'(MAX_POLLS)); // R7
  AST_OVR_ON_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_data_ovr_o) |-> $past(!rx_valid_i && ltssm_i == 6'h0D)); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start |=> done_o && $stable(err_o)); // R11
endmodule

// File: tb/pcie_link_bringup_tb_top.sv
`timescale 1ns/1ps
module pcie_link_bringup_tb_top;
  localparam int CYC = 2, PWR = 3, SET = 5, PRS = 4, POL = 2, OVRU = 3, MAXP = 6;
  localparam logic [3:0] DEFS = 4'd2;
  localparam int PW = CYC*PWR, ST = CYC*SET, PE = CYC*PRS, PL = CYC*POL, OV = CYC*OVRU;
  localparam int T_SPD = 2*PW + ST + 2*PE;
  localparam int T_EN  = T_SPD + 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic link_up = 0, in_train = 0, rx_valid = 1;
  logic [5:0] ltssm = 6'h11;
  logic ep_pwr, refclk_en, core_rst, phy_rst, perst_n, ltssm_en;
  logic [3:0] max_speed;
  logic rx_data_ovr, rx_pll_ovr, busy, done, err;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  pcie_link_bringup #(.CYC_PER_US(CYC), .PWR_US(PWR), .SETTLE_US(SET), .PERST_US(PRS),
    .POLL_US(POL), .OVR_US(OVRU), .MAX_POLLS(MAXP), .DEF_SPEED(DEFS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .link_up_i(link_up), .in_train_i(in_train),
    .ltssm_i(ltssm), .rx_valid_i(rx_valid), .ep_pwr_o(ep_pwr), .refclk_en_o(refclk_en),
    .core_rst_o(core_rst), .phy_rst_o(phy_rst), .perst_n_o(perst_n), .ltssm_en_o(ltssm_en),
    .max_speed_o(max_speed), .rx_data_ovr_o(rx_data_ovr), .rx_pll_ovr_o(rx_pll_ovr),
    .busy_o(busy), .done_o(done), .err_o(err));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int t_pwr, t_clk, t_phy, t_perst, t_spd, t_en, t_done, r_err, ovr_n, ovr_first, ovr_mis, spd_bad;

  // mode 0 up, 1 in training, 2 stuck, 3 wrong code, 4 rx valid, 5 up from poll k
  task automatic run(input int mode, input int k, input bit extra);
    t_pwr = -1; t_clk = -1; t_phy = -1; t_perst = -1; t_spd = -1; t_en = -1;
    t_done = -1; r_err = -1; ovr_n = 0; ovr_first = -1; ovr_mis = 0; spd_bad = 0;
    @(negedge clk);
    link_up  = (mode == 0) || (mode == 1);
    in_train = (mode == 1);
    rx_valid = !(mode == 2 || mode == 3);
    ltssm    = (mode == 3) ? 6'h0C : ((mode == 2 || mode == 4) ? 6'h0D : 6'h11);
    start = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      start = extra && (i == 4 || i == 35 || i == 41);
      if (mode == 5) link_up = (i >= T_EN + (k-1)*PL);
      if (t_pwr < 0 && ep_pwr) t_pwr = i;
      if (t_clk < 0 && refclk_en && !core_rst) t_clk = i;
      if (t_phy < 0 && !phy_rst) t_phy = i;
      if (t_perst < 0 && perst_n) t_perst = i;
      if (t_spd < 0 && max_speed == 4'd1) t_spd = i;
      if (max_speed != 4'd1 && max_speed != DEFS) spd_bad++;
      if (t_en < 0 && ltssm_en) t_en = i;
      if (rx_data_ovr) begin ovr_n++; if (ovr_first < 0) ovr_first = i; end
      if (rx_data_ovr != rx_pll_ovr) ovr_mis++;
      if (done) begin t_done = i; r_err = err; start = 0; break; end
    end
    start = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ep_pwr", ep_pwr, 0); chk("R1 refclk", refclk_en, 0);
    chk("R1 core_rst", core_rst, 1); chk("R1 phy_rst", phy_rst, 1);
    chk("R1 perst_n", perst_n, 0); chk("R1 ltssm_en", ltssm_en, 0);
    chk("R1 speed", max_speed, DEFS); chk("R1 ovr", rx_data_ovr | rx_pll_ovr, 0);
    chk("R1 busy/done/err", {busy, done, err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run(0, 0, 0);
    chk("R2 power rise", t_pwr, PW);
    chk("R3 clock and core reset", t_clk, 2*PW);
    chk("R3 phy reset clear", t_phy, 2*PW + ST);
    chk("R4 perst release", t_perst, 2*PW + ST + PE);
    chk("R5 speed forced", t_spd, T_SPD);
    chk("R5 speed values", spd_bad, 0);
    chk("R4 ltssm enable", t_en, T_EN);
    chk("R6 done time", t_done, T_EN + PL);
    chk("R6 err", r_err, 0);
    chk("R9 no ovr when up", ovr_n, 0);
    repeat (7) @(negedge clk);
    chk("R11 done held", done, 1); chk("R11 err held", err, 0);
    chk("R11 busy low", busy, 0);

    run(1, 0, 0);
    chk("R7 in-training timeout time", t_done, T_EN + MAXP*PL);
    chk("R7 in-training err", r_err, 1);
    chk("R9 no ovr rx valid", ovr_n, 0);
    repeat (4) @(negedge clk);
    chk("R11 err held", err, 1);

    run(2, 0, 0);
    chk("R8 first ovr", ovr_first, T_EN + PL);
    chk("R8 ovr cycles", ovr_n, (MAXP-1)*OV);
    chk("R8 ovr pair", ovr_mis, 0);
    chk("R7 stuck timeout time", t_done, T_EN + MAXP*PL + (MAXP-1)*OV);
    chk("R7 stuck err", r_err, 1);

    run(3, 0, 0);
    chk("R9 code 0C no ovr", ovr_n, 0);
    chk("R9 code 0C timeout", t_done, T_EN + MAXP*PL);
    run(4, 0, 0);
    chk("R9 rx valid no ovr", ovr_n, 0);
    chk("R9 rx valid timeout", t_done, T_EN + MAXP*PL);

    for (int k = 1; k <= MAXP; k++) begin
      run(5, k, 0);
      chk($sformatf("R7 up at poll %0d time", k), t_done, T_EN + k*PL);
      chk($sformatf("R6 up at poll %0d err", k), r_err, 0);
    end

    run(0, 0, 1);
    chk("R10 busy start ignored power", t_pwr, PW);
    chk("R10 busy start ignored done", t_done, T_EN + PL);
    chk("R10 busy start ignored err", r_err, 0);

    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R10 restart busy", busy, 1); chk("R10 restart done", done, 0);
    chk("R10 restart power off", ep_pwr, 0); chk("R10 restart perst", perst_n, 0);
    chk("R10 restart phy rst", phy_rst, 1); chk("R10 restart speed", max_speed, DEFS);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule